// File: doc/BRIEF.md
# Fixed-Point Add/Subtract Unit with Status Flags

This block is the integer add and subtract datapath of a load/store processor's fixed-point pipeline. One operation is presented per cycle with `in_valid`; one clock later the unit presents the 64-bit result, the new carry, overflow, summary-overflow and condition-field values, and a write-enable for each status group. The register file, instruction decode and program counter are outside the block. The only exception is the next-instruction address, which is supplied as an input for the PC-relative form.

The operation code selects the first operand (register or next-instruction address) and whether it is complemented. It also selects the second operand: a register, the sign-extended immediate, the immediate shifted up by sixteen, all ones, or zero. The carry-in can be zero, one, the incoming CA bit or the incoming OV bit. A single two-segment adder produces the carry and the signed overflow of the low 32-bit word and of the full 64-bit value. The 32-bit/64-bit mode bit chooses which of these becomes CA, OV and the compare against zero.

Top module: `fxadd_unit`

## Requirements
- R1: A result appears on the outputs exactly one clock after it is presented with `in_valid`, with `out_valid` high for that one cycle. While `out_valid` is low, and after reset, every write-enable is low.
- R2: Subtract-from forms produce the complement of operand A plus operand B plus one. Negate produces the complement of A plus one.
- R3: Extended forms use the incoming CA as the carry-in. The plain extended forms add B. The minus-one forms add all ones. The zero forms add nothing. Each form is available with A either true or complemented.
- R4: Immediate forms sign-extend the 16-bit immediate. The shifted forms place the immediate in bits 31:16, fill bits 15:0 with zeros and sign-extend above. The PC-relative form adds the shifted immediate to the next-instruction address. The immediate subtract-from form computes the complement of A plus the immediate plus one.
- R5: The carrying, extended, minus-one, zero and immediate-carrying forms raise `ca_we`. Plain add, plain subtract-from, negate, the non-carrying immediate forms and the OV-carry form leave `ca_we` low.
- R6: CA32 is the carry out of bit 31. In 64-bit mode CA is the carry out of bit 63. In 32-bit mode CA equals CA32.
- R7: OV32 is the signed overflow of the low 32-bit word. OV is the overflow of the full 64-bit value in 64-bit mode and equals OV32 in 32-bit mode. `ov_we` is raised for register forms only when OE=1.
- R8: SO is sticky. When register forms write overflow, `so_out` is the incoming SO ORed with the new OV and `so_we` is high. Otherwise `so_out` repeats the incoming SO and `so_we` is low. The unit never clears SO.
- R9: `cr0_we` is raised for register forms only when Rc=1. It is always raised for the recording immediate-carrying form and never for the other immediate forms. `cr0_out` bit 3 is less-than, bit 2 is greater-than, bit 1 is equal and bit 0 is a copy of the updated `so_out`.
- R10: The compare against zero is signed. It uses all 64 result bits in 64-bit mode and only the low 32 bits in 32-bit mode.
- R11: The OV-carry form adds A, B and the incoming OV. It writes the carry out into OV (the 64-bit or 32-bit carry, according to mode) and the low-word carry into OV32. It raises `ov_we` and leaves `ca_we`, `so_we` and `cr0_we` low whatever OE and Rc are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation, encoded by `fxa_op_e` in the package |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| imm16 | input | 16 | Immediate field |
| next_ia | input | 64 | Next-instruction address for the PC-relative form |
| oe_en | input | 1 | Overflow recording enable |
| rc_en | input | 1 | Condition-field recording enable |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| ca_in | input | 1 | Current CA |
| ov_in | input | 1 | Current OV |
| so_in | input | 1 | Current SO |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Sum |
| ca_out | output | 1 | New CA |
| ca32_out | output | 1 | New CA32 |
| ov_out | output | 1 | New OV |
| ov32_out | output | 1 | New OV32 |
| so_out | output | 1 | New SO |
| cr0_out | output | 4 | New condition field {LT, GT, EQ, SO} |
| ca_we | output | 1 | Write CA and CA32 |
| ov_we | output | 1 | Write OV and OV32 |
| so_we | output | 1 | Write SO |
| cr0_we | output | 1 | Write condition field |

## Verification
Overflow accumulation into SO and the condition-field update can happen in the same cycle. When they do, bit 0 of the condition field must carry the SO value just ORed with the fresh overflow, not the stale incoming one. The bench provokes this with a register add that overflows with OE=1, Rc=1 and incoming SO low, and it expects `so_out` and `cr0_out` bit 0 both high. It also checks the reverse case: SO high, no overflow and OE=0. There bit 0 must still read high while `so_we` stays low.

// File: rtl/fxa_pkg.sv
package fxa_pkg;

    typedef enum logic [4:0] {
        OP_ADD      = 5'd0,
        OP_SUBF     = 5'd1,
        OP_ADDI     = 5'd2,
        OP_ADDIS    = 5'd3,
        OP_ADDPCIS  = 5'd4,
        OP_ADDIC    = 5'd5,
        OP_ADDIC_CR = 5'd6,
        OP_SUBFIC   = 5'd7,
        OP_ADDC     = 5'd8,
        OP_SUBFC    = 5'd9,
        OP_ADDE     = 5'd10,
        OP_SUBFE    = 5'd11,
        OP_ADDME    = 5'd12,
        OP_SUBFME   = 5'd13,
        OP_ADDZE    = 5'd14,
        OP_SUBFZE   = 5'd15,
        OP_NEG      = 5'd16,
        OP_ADDEX    = 5'd17
    } fxa_op_e;

    typedef enum logic [2:0] {
        YS_REG, YS_SIMM, YS_SIMM_HI, YS_ONES, YS_ZERO
    } fxa_ysrc_e;

    typedef enum logic [1:0] {
        CI_ZERO, CI_ONE, CI_CA, CI_OV
    } fxa_cin_e;

    typedef struct packed {
        logic      x_from_nia;
        logic      x_inv;
        fxa_ysrc_e y_src;
        fxa_cin_e  cin_sel;
        logic      set_ca;
        logic      oe_form;
        logic      rc_form;
        logic      force_cr;
        logic      ov_carry;
    } fxa_ctrl_t;

    typedef struct packed {
        logic       ca;
        logic       ca32;
        logic       ov;
        logic       ov32;
        logic       so;
        logic [3:0] cr0;
    } fxa_flags_t;

    typedef struct packed {
        logic ca;
        logic ov;
        logic so;
        logic cr;
    } fxa_we_t;

    function automatic fxa_ctrl_t fxa_decode(input logic [4:0] op);
        fxa_ctrl_t c;
        c = '{x_from_nia: 1'b0, x_inv: 1'b0, y_src: YS_REG, cin_sel: CI_ZERO,
              set_ca: 1'b0, oe_form: 1'b0, rc_form: 1'b0, force_cr: 1'b0,
              ov_carry: 1'b0};
        case (op)
            OP_ADD:      begin c.oe_form = 1'b1; c.rc_form = 1'b1; end
            OP_SUBF:     begin c.x_inv = 1'b1; c.cin_sel = CI_ONE;
                               c.oe_form = 1'b1; c.rc_form = 1'b1; end
            OP_ADDI:     c.y_src = YS_SIMM;
            OP_ADDIS:    c.y_src = YS_SIMM_HI;
            OP_ADDPCIS:  begin c.x_from_nia = 1'b1; c.y_src = YS_SIMM_HI; end
            OP_ADDIC:    begin c.y_src = YS_SIMM; c.set_ca = 1'b1; end
            OP_ADDIC_CR: begin c.y_src = YS_SIMM; c.set_ca = 1'b1;
                               c.force_cr = 1'b1; end
            OP_SUBFIC:   begin c.x_inv = 1'b1; c.y_src = YS_SIMM;
                               c.cin_sel = CI_ONE; c.set_ca = 1'b1; end
            OP_ADDC:     begin c.set_ca = 1'b1; c.oe_form = 1'b1; c.rc_form = 1'b1; end
            OP_SUBFC:    begin c.x_inv = 1'b1; c.cin_sel = CI_ONE; c.set_ca = 1'b1;
                               c.oe_form = 1'b1; c.rc_form = 1'b1; end
            OP_ADDE:     begin c.cin_sel = CI_CA; c.set_ca = 1'b1;
                               c.oe_form = 1'b1; c.rc_form = 1'b1; end
            OP_SUBFE:    begin c.x_inv = 1'b1; c.cin_sel = CI_CA; c.set_ca = 1'b1;
                               c.oe_form = 1'b1; c.rc_form = 1'b1; end
            OP_ADDME:    begin c.y_src = YS_ONES; c.cin_sel = CI_CA; c.set_ca = 1'b1;
                               c.oe_form = 1'b1; c.rc_form = 1'b1; end
            OP_SUBFME:   begin c.x_inv = 1'b1; c.y_src = YS_ONES; c.cin_sel = CI_CA;
                               c.set_ca = 1'b1; c.oe_form = 1'b1; c.rc_form = 1'b1; end
            OP_ADDZE:    begin c.y_src = YS_ZERO; c.cin_sel = CI_CA; c.set_ca = 1'b1;
                               c.oe_form = 1'b1; c.rc_form = 1'b1; end
            OP_SUBFZE:   begin c.x_inv = 1'b1; c.y_src = YS_ZERO; c.cin_sel = CI_CA;
                               c.set_ca = 1'b1; c.oe_form = 1'b1; c.rc_form = 1'b1; end
            OP_NEG:      begin c.x_inv = 1'b1; c.y_src = YS_ZERO; c.cin_sel = CI_ONE;
                               c.oe_form = 1'b1; c.rc_form = 1'b1; end
            OP_ADDEX:    begin c.cin_sel = CI_OV; c.ov_carry = 1'b1; end
            default:     ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fxa_opsel.sv
module fxa_opsel
    import fxa_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter int unsigned IMMW = 16
) (
    input  fxa_ctrl_t        ctrl,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    input  logic [XLEN-1:0]  nia,
    input  logic [IMMW-1:0]  imm,
    input  logic             ca_in,
    input  logic             ov_in,
    output logic [XLEN-1:0]  x,
    output logic [XLEN-1:0]  y,
    output logic             cin
);
    localparam int unsigned LO_EXT = XLEN - IMMW;
    localparam int unsigned HI_EXT = XLEN - 2 * IMMW;

    logic [XLEN-1:0] simm_lo;
    logic [XLEN-1:0] simm_hi;
    logic [XLEN-1:0] x_base;

    assign simm_lo = {{LO_EXT{imm[IMMW-1]}}, imm};
    assign simm_hi = {{HI_EXT{imm[IMMW-1]}}, imm, {IMMW{1'b0}}};
    assign x_base  = ctrl.x_from_nia ? nia : a;
    assign x       = ctrl.x_inv ? ~x_base : x_base;

    always_comb begin
        case (ctrl.y_src)
            YS_REG:     y = b;
            YS_SIMM:    y = simm_lo;
            YS_SIMM_HI: y = simm_hi;
            YS_ONES:    y = '1;
            default:    y = '0;
        endcase
    end

    always_comb begin
        case (ctrl.cin_sel)
            CI_ONE:  cin = 1'b1;
            CI_CA:   cin = ca_in;
            CI_OV:   cin = ov_in;
            default: cin = 1'b0;
        endcase
    end
endmodule

// File: rtl/fxa_adder.sv
module fxa_adder #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned WLEN = 32
) (
    input  logic [XLEN-1:0] x,
    input  logic [XLEN-1:0] y,
    input  logic            cin,
    output logic [XLEN-1:0] sum,
    output logic            c_full,
    output logic            c_word,
    output logic            v_full,
    output logic            v_word
);
    localparam int unsigned HLEN = XLEN - WLEN;

    logic [WLEN:0] lo_sum;

    assign lo_sum = {1'b0, x[WLEN-1:0]} + {1'b0, y[WLEN-1:0]} + {{WLEN{1'b0}}, cin};
    assign c_word = lo_sum[WLEN];
    assign sum[WLEN-1:0] = lo_sum[WLEN-1:0];
    assign v_word = (x[WLEN-1] == y[WLEN-1]) && (lo_sum[WLEN-1] != x[WLEN-1]);

    generate
        if (HLEN > 0) begin : g_upper
            logic [HLEN:0] hi_sum;
            assign hi_sum = {1'b0, x[XLEN-1:WLEN]} + {1'b0, y[XLEN-1:WLEN]}
                          + {{HLEN{1'b0}}, c_word};
            assign sum[XLEN-1:WLEN] = hi_sum[HLEN-1:0];
            assign c_full = hi_sum[HLEN];
            assign v_full = (x[XLEN-1] == y[XLEN-1]) && (hi_sum[HLEN-1] != x[XLEN-1]);
        end else begin : g_single
            assign c_full = c_word;
            assign v_full = v_word;
        end
    endgenerate
endmodule

// File: rtl/fxa_flags.sv
module fxa_flags
    import fxa_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter int unsigned WLEN = 32
) (
    input  fxa_ctrl_t       ctrl,
    input  logic            oe,
    input  logic            rc,
    input  logic            mode64,
    input  logic            so_in,
    input  logic [XLEN-1:0] sum,
    input  logic            c_full,
    input  logic            c_word,
    input  logic            v_full,
    input  logic            v_word,
    output fxa_flags_t      flags,
    output fxa_we_t         we
);
    localparam int unsigned SEXT = XLEN - WLEN;

    logic [XLEN-1:0] cmp_val;
    logic            carry_sel;
    logic            ovf_sel;
    logic            lt;
    logic            eq;

    assign carry_sel = mode64 ? c_full : c_word;
    assign ovf_sel   = mode64 ? v_full : v_word;
    assign cmp_val   = mode64 ? sum : {{SEXT{sum[WLEN-1]}}, sum[WLEN-1:0]};
    assign lt        = cmp_val[XLEN-1];
    assign eq        = (cmp_val == '0);

    always_comb begin
        we.ca      = ctrl.set_ca;
        we.cr      = ctrl.force_cr | (ctrl.rc_form & rc);
        we.ov      = 1'b0;
        we.so      = 1'b0;
        flags.ca   = carry_sel;
        flags.ca32 = c_word;
        flags.ov   = ovf_sel;
        flags.ov32 = v_word;
        flags.so   = so_in;
        if (ctrl.ov_carry) begin
            flags.ov   = carry_sel;
            flags.ov32 = c_word;
            we.ov      = 1'b1;
        end else if (ctrl.oe_form && oe) begin
            flags.so   = so_in | ovf_sel;
            we.ov      = 1'b1;
            we.so      = 1'b1;
        end
        flags.cr0 = {lt, !lt && !eq, eq, flags.so};
    end
endmodule

// File: rtl/fxadd_unit.sv
module fxadd_unit
    import fxa_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter int unsigned WLEN = 32,
    parameter int unsigned IMMW = 16,
    parameter int unsigned OPW  = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [OPW-1:0]  op_code,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic [IMMW-1:0] imm16,
    input  logic [XLEN-1:0] next_ia,
    input  logic            oe_en,
    input  logic            rc_en,
    input  logic            mode64,
    input  logic            ca_in,
    input  logic            ov_in,
    input  logic            so_in,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic            ca_out,
    output logic            ca32_out,
    output logic            ov_out,
    output logic            ov32_out,
    output logic            so_out,
    output logic [3:0]      cr0_out,
    output logic            ca_we,
    output logic            ov_we,
    output logic            so_we,
    output logic            cr0_we
);
    fxa_ctrl_t       ctrl;
    logic [XLEN-1:0] x_opnd;
    logic [XLEN-1:0] y_opnd;
    logic            cin;
    logic [XLEN-1:0] sum;
    logic            c_full, c_word, v_full, v_word;
    fxa_flags_t      flags_d, flags_q;
    fxa_we_t         we_d, we_q;
    logic [XLEN-1:0] res_q;
    logic            vld_q;

    assign ctrl = fxa_decode(op_code);

    fxa_opsel #(.XLEN(XLEN), .IMMW(IMMW)) u_opsel (
        .ctrl(ctrl), .a(opnd_a), .b(opnd_b), .nia(next_ia), .imm(imm16),
        .ca_in(ca_in), .ov_in(ov_in), .x(x_opnd), .y(y_opnd), .cin(cin)
    );

    fxa_adder #(.XLEN(XLEN), .WLEN(WLEN)) u_adder (
        .x(x_opnd), .y(y_opnd), .cin(cin), .sum(sum),
        .c_full(c_full), .c_word(c_word), .v_full(v_full), .v_word(v_word)
    );

    fxa_flags #(.XLEN(XLEN), .WLEN(WLEN)) u_flags (
        .ctrl(ctrl), .oe(oe_en), .rc(rc_en), .mode64(mode64), .so_in(so_in),
        .sum(sum), .c_full(c_full), .c_word(c_word), .v_full(v_full),
        .v_word(v_word), .flags(flags_d), .we(we_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q   <= 1'b0;
            res_q   <= '0;
            flags_q <= '0;
            we_q    <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                res_q   <= sum;
                flags_q <= flags_d;
                we_q    <= we_d;
            end else begin
                we_q    <= '0;
            end
        end
    end

    assign out_valid = vld_q;
    assign result    = res_q;
    assign ca_out    = flags_q.ca;
    assign ca32_out  = flags_q.ca32;
    assign ov_out    = flags_q.ov;
    assign ov32_out  = flags_q.ov32;
    assign so_out    = flags_q.so;
    assign cr0_out   = flags_q.cr0;
    assign ca_we     = we_q.ca;
    assign ov_we     = we_q.ov;
    assign so_we     = we_q.so;
    assign cr0_we    = we_q.cr;

    AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R1
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(ca_we || ov_we || so_we || cr0_we)); // R1
    AST_PLAIN_KEEPS_CA: assert property (@(posedge clk) disable iff (rst)
        out_valid && ($past(op_code) == OP_ADD || $past(op_code) == OP_SUBF
                      || $past(op_code) == OP_NEG) |-> !ca_we); // R5
    AST_CA_NARROW_MODE: assert property (@(posedge clk) disable iff (rst)
        out_valid && !$past(mode64) |-> ca_out == ca32_out); // R6
    AST_OE_GATES_OV: assert property (@(posedge clk) disable iff (rst)
        out_valid && !$past(oe_en) && $past(op_code) != OP_ADDEX |-> !ov_we); // R7
    AST_SO_NEVER_CLEARED: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(so_in) |-> so_out); // R8
    AST_CR_SO_COPY: assert property (@(posedge clk) disable iff (rst)
        out_valid && cr0_we |-> cr0_out[0] == so_out); // R9
    AST_CR_ONE_RELATION: assert property (@(posedge clk) disable iff (rst)
        out_valid && cr0_we |-> $countones(cr0_out[3:1]) == 1); // R10
    AST_OVCARRY_WRITES: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(op_code) == OP_ADDEX
        |-> ov_we && !ca_we && !so_we && !cr0_we); // R11
endmodule

// File: tb/fxadd_unit_tb.sv
module fxadd_unit_tb_top;
    import fxa_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic [63:0] opnd_a = '0, opnd_b = '0, next_ia = '0;
    logic [15:0] imm16 = '0;
    logic        oe_en = 1'b0, rc_en = 1'b0, mode64 = 1'b1;
    logic        ca_in = 1'b0, ov_in = 1'b0, so_in = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic        ca_out, ca32_out, ov_out, ov32_out, so_out;
    logic [3:0]  cr0_out;
    logic        ca_we, ov_we, so_we, cr0_we;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fxadd_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .imm16(imm16), .next_ia(next_ia),
        .oe_en(oe_en), .rc_en(rc_en), .mode64(mode64), .ca_in(ca_in),
        .ov_in(ov_in), .so_in(so_in), .out_valid(out_valid), .result(result),
        .ca_out(ca_out), .ca32_out(ca32_out), .ov_out(ov_out),
        .ov32_out(ov32_out), .so_out(so_out), .cr0_out(cr0_out),
        .ca_we(ca_we), .ov_we(ov_we), .so_we(so_we), .cr0_we(cr0_we)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Expected values, derived from the requirements.
    logic [63:0] e_res;
    logic e_ca, e_ca32, e_ov, e_ov32, e_so, e_cawe, e_ovwe, e_sowe, e_crwe;
    logic [3:0] e_cr;

    task automatic model(input fxa_op_e op, input logic [63:0] a, input logic [63:0] b,
                         input logic [15:0] imm, input logic [63:0] nia,
                         input logic oe, input logic rc, input logic m64,
                         input logic ca, input logic ov, input logic so);
        logic [63:0] xv, yv, sx, sh, cmpv;
        logic cin, inv, carry_f, reg_f, crf, exov, c64, c32, v64, v32;
        logic [64:0] full;
        logic [32:0] w;
        logic [65:0] sw;
        logic [32:0] sw32;
        sx = 64'($signed(imm));
        sh = 64'($signed({imm, 16'h0000}));
        xv = a; yv = b; cin = 1'b0; inv = 1'b0;
        carry_f = 1'b0; reg_f = 1'b0; crf = 1'b0; exov = 1'b0;
        case (op)
            OP_ADD:      reg_f = 1'b1;
            OP_SUBF:     begin inv = 1'b1; cin = 1'b1; reg_f = 1'b1; end
            OP_ADDI:     yv = sx;
            OP_ADDIS:    yv = sh;
            OP_ADDPCIS:  begin xv = nia; yv = sh; end
            OP_ADDIC:    begin yv = sx; carry_f = 1'b1; end
            OP_ADDIC_CR: begin yv = sx; carry_f = 1'b1; crf = 1'b1; end
            OP_SUBFIC:   begin inv = 1'b1; yv = sx; cin = 1'b1; carry_f = 1'b1; end
            OP_ADDC:     begin reg_f = 1'b1; carry_f = 1'b1; end
            OP_SUBFC:    begin inv = 1'b1; cin = 1'b1; reg_f = 1'b1; carry_f = 1'b1; end
            OP_ADDE:     begin cin = ca; reg_f = 1'b1; carry_f = 1'b1; end
            OP_SUBFE:    begin inv = 1'b1; cin = ca; reg_f = 1'b1; carry_f = 1'b1; end
            OP_ADDME:    begin yv = '1; cin = ca; reg_f = 1'b1; carry_f = 1'b1; end
            OP_SUBFME:   begin inv = 1'b1; yv = '1; cin = ca; reg_f = 1'b1; carry_f = 1'b1; end
            OP_ADDZE:    begin yv = '0; cin = ca; reg_f = 1'b1; carry_f = 1'b1; end
            OP_SUBFZE:   begin inv = 1'b1; yv = '0; cin = ca; reg_f = 1'b1; carry_f = 1'b1; end
            OP_NEG:      begin inv = 1'b1; yv = '0; cin = 1'b1; reg_f = 1'b1; end
            OP_ADDEX:    begin cin = ov; exov = 1'b1; end
            default:     ;
        endcase
        if (inv) xv = ~xv;
        full = {1'b0, xv} + {1'b0, yv} + {64'd0, cin};
        w    = {1'b0, xv[31:0]} + {1'b0, yv[31:0]} + {32'd0, cin};
        sw   = {xv[63], xv[63], xv} + {yv[63], yv[63], yv} + {65'd0, cin};
        sw32 = {xv[31], xv[31:0]} + {yv[31], yv[31:0]} + {32'd0, cin};
        c64 = full[64]; c32 = w[32];
        v64 = sw[64] != sw[63]; v32 = sw32[32] != sw32[31];
        e_res  = full[63:0];
        e_cawe = carry_f;
        e_ca   = m64 ? c64 : c32;
        e_ca32 = c32;
        e_so   = so; e_ovwe = 1'b0; e_sowe = 1'b0;
        e_ov   = m64 ? v64 : v32; e_ov32 = v32;
        if (exov) begin
            e_ov = m64 ? c64 : c32; e_ov32 = c32; e_ovwe = 1'b1;
        end else if (reg_f && oe) begin
            e_ovwe = 1'b1; e_sowe = 1'b1; e_so = so | e_ov;
        end
        e_crwe = crf | (reg_f & rc);
        cmpv = m64 ? e_res : 64'($signed(e_res[31:0]));
        e_cr = {$signed(cmpv) < 0, $signed(cmpv) > 0, cmpv == 0, e_so};
    endtask

    task automatic run(input string tag, input fxa_op_e op,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic [15:0] imm, input logic [63:0] nia,
                       input logic oe, input logic rc, input logic m64,
                       input logic ca, input logic ov, input logic so);
        model(op, a, b, imm, nia, oe, rc, m64, ca, ov, so);
        op_code = op; opnd_a = a; opnd_b = b; imm16 = imm; next_ia = nia;
        oe_en = oe; rc_en = rc; mode64 = m64; ca_in = ca; ov_in = ov; so_in = so;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, "out_valid", 64'(out_valid), 64'd1);
        check(tag, "result", result, e_res);
        check(tag, "ca_we", 64'(ca_we), 64'(e_cawe));
        if (e_cawe) begin
            check(tag, "ca", 64'(ca_out), 64'(e_ca));
            check(tag, "ca32", 64'(ca32_out), 64'(e_ca32));
        end
        check(tag, "ov_we", 64'(ov_we), 64'(e_ovwe));
        if (e_ovwe) begin
            check(tag, "ov", 64'(ov_out), 64'(e_ov));
            check(tag, "ov32", 64'(ov32_out), 64'(e_ov32));
        end
        check(tag, "so_we", 64'(so_we), 64'(e_sowe));
        check(tag, "so", 64'(so_out), 64'(e_so));
        check(tag, "cr0_we", 64'(cr0_we), 64'(e_crwe));
        if (e_crwe) check(tag, "cr0", 64'(cr0_out), 64'(e_cr));
    endtask

    task automatic t_reset;
        check("R1", "reset out_valid", 64'(out_valid), 64'd0);
        check("R1", "reset write enables", 64'({ca_we, ov_we, so_we, cr0_we}), 64'd0);
    endtask

    task automatic t_basic;
        run("R1", OP_ADD, 64'd5, 64'd7, 16'h0, 64'h0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R1", "sum 5+7", result, 64'd12);
        @(negedge clk);
        check("R1", "valid drops", 64'(out_valid), 64'd0);
        check("R1", "idle write enables", 64'({ca_we, ov_we, so_we, cr0_we}), 64'd0);
    endtask

    task automatic t_subtract;
        run("R2", OP_SUBF, 64'd3, 64'd10, 16'h0, 64'h0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R2", "10-3", result, 64'd7);
        run("R2", OP_NEG, 64'd1, 64'h0, 16'h0, 64'h0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R2", "neg 1", result, '1);
        run("R7", OP_NEG, 64'h8000_0000_0000_0000, 64'h0, 16'h0, 64'h0,
            1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R7", "neg min overflows", 64'(ov_out), 64'd1);
        run("R5", OP_SUBFC, 64'd9, 64'd4, 16'h0, 64'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_carry;
        run("R6", OP_ADDC, '1, 64'd1, 16'h0, 64'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R6", "full wrap carry", 64'({ca_out, ca32_out}), 64'd3);
        run("R6", OP_ADDC, 64'h0000_0000_FFFF_FFFF, 64'd1, 16'h0, 64'h0,
            1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R6", "word carry only", 64'({ca_out, ca32_out}), 64'd1);
        run("R6", OP_ADDC, 64'h0000_0000_FFFF_FFFF, 64'd1, 16'h0, 64'h0,
            1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R6", "narrow mode carry", 64'({ca_out, ca32_out}), 64'd3);
    endtask

    task automatic t_extended;
        run("R3", OP_ADDE, 64'd10, 64'd20, 16'h0, 64'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R3", "adde with CA", result, 64'd31);
        run("R3", OP_ADDME, 64'd0, 64'h0, 16'h0, 64'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R3", "minus-one", result, '1);
        run("R3", OP_ADDZE, 64'd41, 64'h0, 16'h0, 64'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        run("R3", OP_SUBFE, 64'd5, 64'd9, 16'h0, 64'h0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        run("R3", OP_SUBFME, 64'd0, 64'h0, 16'h0, 64'h0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        run("R3", OP_SUBFZE, 64'd0, 64'h0, 16'h0, 64'h0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_immediates;
        run("R4", OP_ADDI, 64'd100, 64'h0, 16'hFFFF, 64'h0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R4", "addi -1", result, 64'd99);
        run("R4", OP_ADDIS, 64'd0, 64'h0, 16'h8000, 64'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R4", "shifted sign extend", result, 64'hFFFF_FFFF_8000_0000);
        run("R4", OP_ADDPCIS, 64'hDEAD, 64'h0, 16'h0001, 64'h0000_0000_0040_0004,
            1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R4", "pc relative", result, 64'h0000_0000_0041_0004);
        run("R4", OP_SUBFIC, 64'd8, 64'h0, 16'd20, 64'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R4", "subfic", result, 64'd12);
        run("R5", OP_ADDIC, '1, 64'h0, 16'd1, 64'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_word_overflow;
        run("R10", OP_ADD, 64'h0000_0000_7FFF_FFFF, 64'd1, 16'h0, 64'h0,
            1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R10", "narrow compare negative", 64'(cr0_out), 64'b1001);
        run("R7", OP_ADD, 64'h0000_0000_7FFF_FFFF, 64'd1, 16'h0, 64'h0,
            1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R7", "wide ov clear, ov32 set", 64'({ov_out, ov32_out}), 64'd1);
        run("R10", OP_ADD, 64'h1234_0000_0000_0000, 64'd0, 16'h0, 64'h0,
            1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R10", "narrow compare equal", 64'(cr0_out), 64'b0010);
    endtask

    task automatic t_gating;
        run("R9", OP_ADD, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'h0, 64'h0,
            1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        run("R9", OP_ADDIC_CR, 64'd0, 64'h0, 16'hFFFE, 64'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R9", "forced record lt", 64'(cr0_out), 64'b1000);
        run("R9", OP_ADDI, 64'd0, 64'h0, 16'h5, 64'h0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_sticky;
        run("R8", OP_ADD, 64'd1, 64'd1, 16'h0, 64'h0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        check("R8", "so kept with no overflow", 64'(so_out), 64'd1);
        run("R8", OP_ADD, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'h0, 64'h0,
            1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R8", "fresh so in cr0", 64'({so_out, cr0_out[0]}), 64'd3);
        run("R8", OP_ADD, 64'd2, 64'd2, 16'h0, 64'h0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        check("R8", "so copy without write", 64'({so_we, cr0_out[0]}), 64'd1);
    endtask

    task automatic t_ovcarry;
        run("R11", OP_ADDEX, '1, 64'd0, 16'h0, 64'h0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R11", "ov carry out", 64'({ov_out, ov32_out}), 64'd3);
        check("R11", "oe/rc ignored", 64'({ca_we, so_we, cr0_we}), 64'd0);
        run("R11", OP_ADDEX, 64'h0000_0000_FFFF_FFFF, 64'd0, 16'h0, 64'h0,
            1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R11", "word carry only", 64'({ov_out, ov32_out}), 64'd1);
        run("R11", OP_ADDEX, 64'd4, 64'd5, 16'h0, 64'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R11", "CA not used as carry", result, 64'd9);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_subtract();
        t_carry();
        t_extended();
        t_immediates();
        t_word_overflow();
        t_gating();
        t_sticky();
        t_ovcarry();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule